// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Core

This block is a small 32-bit processor core that retires one instruction on every rising clock edge. It decodes a nine-instruction subset: three-register arithmetic and logic, word load, word store, branch-if-equal and an absolute jump. A program counter addresses a private instruction store. Two register operands are read from a 32-entry register file. An ALU with a zero flag computes a result, and on the same edge either a register, a data word or the program counter takes the result.

The core has two on-die word arrays, one for instructions and one for data. A load port, used while the core is held in reset, writes either array. Two combinational peek ports read any register and any data word, so the surrounding test logic can check the architectural state. Control has two levels. The opcode selects an ALU request class (add, subtract, or "decode the function field"), and a second decoder turns that class into one of six 4-bit ALU codes.

Top module: `onecycle_cpu`

## Requirements
- R1: While `rst` is high the program counter reads 0 and no register or data-memory write from an instruction takes place; after release the instruction at byte address 0 executes first.
- R2: Opcode 0 (bits 31:26) with function field (bits 5:0) 0x20, 0x22, 0x24 or 0x25 writes the sum, difference (rs minus rt), bitwise AND or bitwise OR of registers rs (bits 25:21) and rt (bits 20:16) into register rd (bits 15:11).
- R3: Opcode 0 with function 0x2A writes 1 into rd when rs is less than rt as signed two's complement numbers, and 0 otherwise.
- R4: An all-zero word, an opcode-0 word with any other function value, and any opcode other than 0, 2, 4, 35 and 43 change no register and no data word, and advance the program counter by 4.
- R5: Register 0 always reads as zero; writes aimed at it are dropped.
- R6: Opcode 35 writes into rt the data word at byte address rs + sign-extended bits 15:0; the array index is address bits 7:2 (low two bits ignored, wrap modulo the depth).
- R7: Opcode 43 stores rt into the data word at byte address rs + sign-extended bits 15:0, indexed the same way as R6.
- R8: Opcode 4 sets the next PC to PC+4 + (sign-extended bits 15:0 shifted left 2) when rs equals rt, and to PC+4 otherwise.
- R9: Opcode 2 sets the next PC to the current PC bits 31:28, then instruction bits 25:0, then two zero bits.
- R10: Every other instruction sets the next PC to PC+4; instruction fetch uses PC bits 7:2 as the word index.
- R11: With `loadEn` high, the word `loadData` is written at the rising edge into the data array when `loadToData` is 1, or into the instruction array when it is 0, at word index `loadAddr`; the peek ports read the state combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| loadEn | input | 1 | Write strobe of the preload port |
| loadToData | input | 1 | 1 selects the data array, 0 the instruction array |
| loadAddr | input | 6 | Word index of the preload write |
| loadData | input | 32 | Word to preload |
| peekReg | input | 5 | Register number to observe |
| peekRegData | output | 32 | Value of the observed register |
| peekMemAddr | input | 6 | Data-array word index to observe |
| peekMemData | output | 32 | Value of the observed data word |
| pc | output | 32 | Current program counter (byte address) |

## Verification
The hardest state to reach is a taken branch. It needs two registers that hold equal values at the moment the branch is fetched, and the programs reach it only by chance after random jumps and stores. The stimulus seeds every register from data memory through a prefix of loads. A third of the random branches reuse the same register for both operands, and the offsets stay small, so taken and not-taken branches both occur often. The same random programs contain jumps to any word, stores at wrapping addresses, and unsupported encodings. The next-PC logic and the write gating are therefore exercised while the architectural state is already dense.

// File: rtl/ocpu_pkg.sv
package ocpu_pkg;

  localparam logic [5:0] OPC_REG   = 6'd0;
  localparam logic [5:0] OPC_JUMP  = 6'd2;
  localparam logic [5:0] OPC_BEQ   = 6'd4;
  localparam logic [5:0] OPC_LOAD  = 6'd35;
  localparam logic [5:0] OPC_STORE = 6'd43;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  // request class produced by the first decode level
  typedef enum logic [1:0] {
    REQ_ADD   = 2'b00,
    REQ_SUB   = 2'b01,
    REQ_FUNCT = 2'b10
  } aluReq_e;

  // operation code seen by the ALU
  typedef enum logic [3:0] {
    ALU_AND = 4'b0000,
    ALU_OR  = 4'b0001,
    ALU_ADD = 4'b0010,
    ALU_SUB = 4'b0110,
    ALU_SLT = 4'b0111,
    ALU_NOR = 4'b1100
  } aluFn_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   destIsRd;
    logic   useImm;
    logic   wbFromMem;
    logic   regWrite;
    logic   memWrite;
    logic   branch;
    logic   jump;
    aluFn_e aluFn;
  } ctrl_t;

endpackage

// File: rtl/ocpu_ctrl.sv
module ocpu_ctrl
  import ocpu_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctl
);

  aluReq_e req;
  aluFn_e  functFn;
  logic    functOk;
  logic    writesReg;

  // second level: function field decode
  always_comb begin
    functOk = 1'b1;
    case (funct)
      FN_ADD:  functFn = ALU_ADD;
      FN_SUB:  functFn = ALU_SUB;
      FN_AND:  functFn = ALU_AND;
      FN_OR:   functFn = ALU_OR;
      FN_SLT:  functFn = ALU_SLT;
      default: begin
        functFn = ALU_AND;
        functOk = 1'b0;
      end
    endcase
  end

  // first level: opcode decode
  always_comb begin
    ctl       = '0;
    req       = REQ_ADD;
    writesReg = 1'b0;
    case (opcode)
      OPC_REG: begin
        ctl.destIsRd = 1'b1;
        writesReg    = 1'b1;
        req          = REQ_FUNCT;
      end
      OPC_LOAD: begin
        ctl.useImm    = 1'b1;
        ctl.wbFromMem = 1'b1;
        writesReg     = 1'b1;
      end
      OPC_STORE: begin
        ctl.useImm   = 1'b1;
        ctl.memWrite = 1'b1;
      end
      OPC_BEQ: begin
        ctl.branch = 1'b1;
        req        = REQ_SUB;
      end
      OPC_JUMP: ctl.jump = 1'b1;
      default: ;
    endcase
    case (req)
      REQ_ADD: ctl.aluFn = ALU_ADD;
      REQ_SUB: ctl.aluFn = ALU_SUB;
      default: ctl.aluFn = functFn;
    endcase
    ctl.regWrite = writesReg && ((req != REQ_FUNCT) || functOk);
  end

endmodule

// File: rtl/ocpu_alu.sv
module ocpu_alu
  import ocpu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  aluFn_e       fn,
  output logic [W-1:0] res,
  output logic         zero
);

  always_comb begin
    case (fn)
      ALU_AND: res = opA & opB;
      ALU_OR:  res = opA | opB;
      ALU_ADD: res = opA + opB;
      ALU_SUB: res = opA - opB;
      ALU_SLT: res = {{(W-1){1'b0}}, ($signed(opA) < $signed(opB))};
      ALU_NOR: res = ~(opA | opB);
      default: res = '0;
    endcase
  end

  assign zero = (res == '0);

endmodule

// File: rtl/ocpu_regfile.sv
module ocpu_regfile #(
  parameter int W   = 32,
  parameter int AW  = 5,
  parameter int NRD = 3
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [AW-1:0]           wAddr,
  input  logic [W-1:0]            wData,
  input  logic [NRD-1:0][AW-1:0]  rAddr,
  output logic [NRD-1:0][W-1:0]   rData
);

  localparam int NREG = 1 << AW;

  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (we && (wAddr != '0)) regs[wAddr] <= wData;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rData[p] = (rAddr[p] == '0) ? '0 : regs[rAddr[p]];
  end

endmodule

// File: rtl/ocpu_datapath.sv
module ocpu_datapath
  import ocpu_pkg::*;
#(
  parameter int IMEM_AW = 6,
  parameter int DMEM_AW = 6,
  parameter int LOAD_AW = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  ctrl_t              ctl,
  output logic [31:0]        instr,
  input  logic               loadEn,
  input  logic               loadToData,
  input  logic [LOAD_AW-1:0] loadAddr,
  input  logic [31:0]        loadData,
  input  logic [4:0]         peekReg,
  output logic [31:0]        peekRegData,
  input  logic [DMEM_AW-1:0] peekMemAddr,
  output logic [31:0]        peekMemData,
  output logic [31:0]        pc
);

  localparam int IMEM_WORDS = 1 << IMEM_AW;
  localparam int DMEM_WORDS = 1 << DMEM_AW;

  logic [31:0] imem [IMEM_WORDS];
  logic [31:0] dmem [DMEM_WORDS];

  logic [31:0] pcQ, pcNext, pcPlus4, brTarget, jTarget;
  logic [4:0]  rsIdx, rtIdx, rdIdx, wIdx;
  logic [31:0] immExt, rsVal, rtVal, aluB, aluY, memWord, wbData;
  logic        aluZero, regWe;
  logic [2:0][4:0]  rfAddr;
  logic [2:0][31:0] rfData;

  assign instr  = imem[pcQ[2 +: IMEM_AW]];
  assign rsIdx  = instr[25:21];
  assign rtIdx  = instr[20:16];
  assign rdIdx  = instr[15:11];
  assign immExt = {{16{instr[15]}}, instr[15:0]};

  assign rfAddr = {peekReg, rtIdx, rsIdx};
  assign rsVal  = rfData[0];
  assign rtVal  = rfData[1];
  assign peekRegData = rfData[2];

  assign wIdx   = ctl.destIsRd ? rdIdx : rtIdx;
  assign regWe  = ctl.regWrite && !rst;

  ocpu_regfile #(.W(32), .AW(5), .NRD(3)) rf_i (
    .clk   (clk),
    .we    (regWe),
    .wAddr (wIdx),
    .wData (wbData),
    .rAddr (rfAddr),
    .rData (rfData)
  );

  assign aluB = ctl.useImm ? immExt : rtVal;

  ocpu_alu #(.W(32)) alu_i (
    .opA  (rsVal),
    .opB  (aluB),
    .fn   (ctl.aluFn),
    .res  (aluY),
    .zero (aluZero)
  );

  assign memWord     = dmem[aluY[2 +: DMEM_AW]];
  assign wbData      = ctl.wbFromMem ? memWord : aluY;
  assign peekMemData = dmem[peekMemAddr];

  assign pcPlus4  = pcQ + 32'd4;
  assign brTarget = pcPlus4 + {immExt[29:0], 2'b00};
  assign jTarget  = {pcQ[31:28], instr[25:0], 2'b00};

  always_comb begin
    if (ctl.jump)                  pcNext = jTarget;
    else if (ctl.branch && aluZero) pcNext = brTarget;
    else                           pcNext = pcPlus4;
  end

  always_ff @(posedge clk) begin
    if (rst) pcQ <= '0;
    else     pcQ <= pcNext;
  end

  always_ff @(posedge clk) begin
    if (loadEn && !loadToData) imem[loadAddr[IMEM_AW-1:0]] <= loadData;
  end

  always_ff @(posedge clk) begin
    if (loadEn && loadToData)       dmem[loadAddr[DMEM_AW-1:0]] <= loadData;
    else if (ctl.memWrite && !rst)  dmem[aluY[2 +: DMEM_AW]] <= rtVal;
  end

  assign pc = pcQ;

  AST_SEQ_PC: assert property (@(posedge clk) disable iff (rst)
    (!ctl.branch && !ctl.jump) |=> (pcQ == $past(pcQ) + 32'd4)); // R10
  AST_BRANCH_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (ctl.branch && (rsVal == rtVal)) |=>
      (pcQ == $past(pcQ) + 32'd4 + ($past(immExt) << 2))); // R8
  AST_BRANCH_NOT_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (ctl.branch && (rsVal != rtVal)) |=> (pcQ == $past(pcQ) + 32'd4)); // R8
  AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (rst)
    ctl.jump |=> (pcQ == {$past(pcQ[31:28]), $past(instr[25:0]), 2'b00})); // R9
  AST_ONE_EFFECT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctl.regWrite, ctl.memWrite, ctl.branch, ctl.jump})); // R4
  AST_SLT_BOOLEAN: assert property (@(posedge clk) disable iff (rst)
    (ctl.aluFn == ALU_SLT) |-> (aluY[31:1] == '0)); // R3

endmodule

// File: rtl/onecycle_cpu.sv
module onecycle_cpu
  import ocpu_pkg::*;
#(
  parameter int IMEM_AW = 6,
  parameter int DMEM_AW = 6,
  localparam int LOAD_AW = (IMEM_AW > DMEM_AW) ? IMEM_AW : DMEM_AW
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               loadEn,
  input  logic               loadToData,
  input  logic [LOAD_AW-1:0] loadAddr,
  input  logic [31:0]        loadData,
  input  logic [4:0]         peekReg,
  output logic [31:0]        peekRegData,
  input  logic [DMEM_AW-1:0] peekMemAddr,
  output logic [31:0]        peekMemData,
  output logic [31:0]        pc
);

  ctrl_t       ctl;
  logic [31:0] instr;

  ocpu_ctrl ctrl_i (
    .opcode (instr[31:26]),
    .funct  (instr[5:0]),
    .ctl    (ctl)
  );

  ocpu_datapath #(
    .IMEM_AW (IMEM_AW),
    .DMEM_AW (DMEM_AW),
    .LOAD_AW (LOAD_AW)
  ) dp_i (
    .clk         (clk),
    .rst         (rst),
    .ctl         (ctl),
    .instr       (instr),
    .loadEn      (loadEn),
    .loadToData  (loadToData),
    .loadAddr    (loadAddr),
    .loadData    (loadData),
    .peekReg     (peekReg),
    .peekRegData (peekRegData),
    .peekMemAddr (peekMemAddr),
    .peekMemData (peekMemData),
    .pc          (pc)
  );

endmodule

// File: tb/onecycle_cpu_tb_top.sv
`timescale 1ns/1ps
module onecycle_cpu_tb_top;

  localparam real HALF = 2.5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        loadEn = 1'b0;
  logic        loadToData = 1'b0;
  logic [5:0]  loadAddr = '0;
  logic [31:0] loadData = '0;
  logic [4:0]  peekReg = '0;
  logic [31:0] peekRegData;
  logic [5:0]  peekMemAddr = '0;
  logic [31:0] peekMemData;
  logic [31:0] pc;

  int nCmp = 0;
  int nBad = 0;

  logic [31:0] mReg [32];
  logic        mValid [32];
  logic [31:0] mDmem [64];
  logic [31:0] mImem [64];
  logic [31:0] mPc;
  string       lastTag;

  always #(HALF) clk = ~clk;

  onecycle_cpu dut_i (
    .clk (clk), .rst (rst), .loadEn (loadEn), .loadToData (loadToData),
    .loadAddr (loadAddr), .loadData (loadData), .peekReg (peekReg),
    .peekRegData (peekRegData), .peekMemAddr (peekMemAddr),
    .peekMemData (peekMemData), .pc (pc)
  );

  function automatic logic [31:0] encR(input int rs, rt, rd, input logic [5:0] fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] encI(input int op, rs, rt, input logic [15:0] imm);
    return {6'(op), 5'(rs), 5'(rt), imm};
  endfunction
  function automatic logic [31:0] encJ(input int tgt);
    return {6'd2, 26'(tgt)};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  endtask

  function automatic logic [31:0] rd(input logic [4:0] i);
    return (i == 0) ? 32'd0 : mReg[i];
  endfunction

  task automatic mWrite(input logic [4:0] i, input logic [31:0] v);
    if (i != 0) begin
      mReg[i] = v;
      mValid[i] = 1'b1;
    end
  endtask

  // reference model: one instruction
  task automatic mStep();
    logic [31:0] ins, a, b, sx, addr, nxt;
    ins  = mImem[mPc[7:2]];
    a    = rd(ins[25:21]);
    b    = rd(ins[20:16]);
    sx   = {{16{ins[15]}}, ins[15:0]};
    addr = a + sx;
    nxt  = mPc + 32'd4;
    lastTag = "R10 next pc";
    case (ins[31:26])
      6'd0: case (ins[5:0])
        6'h20: mWrite(ins[15:11], a + b);
        6'h22: mWrite(ins[15:11], a - b);
        6'h24: mWrite(ins[15:11], a & b);
        6'h25: mWrite(ins[15:11], a | b);
        6'h2A: mWrite(ins[15:11], {31'd0, $signed(a) < $signed(b)});
        default: lastTag = "R4 next pc";
      endcase
      6'd35: mWrite(ins[20:16], mDmem[addr[7:2]]);
      6'd43: mDmem[addr[7:2]] = b;
      6'd4: begin
        lastTag = "R8 next pc";
        if (a == b) nxt = mPc + 32'd4 + {sx[29:0], 2'b00};
      end
      6'd2: begin
        lastTag = "R9 next pc";
        nxt = {mPc[31:28], ins[25:0], 2'b00};
      end
      default: lastTag = "R4 next pc";
    endcase
    mPc = nxt;
  endtask

  task automatic loadAll();
    for (int i = 0; i < 128; i++) begin
      @(negedge clk);
      loadEn     = 1'b1;
      loadToData = (i >= 64);
      loadAddr   = 6'(i % 64);
      loadData   = (i >= 64) ? mDmem[i - 64] : mImem[i];
    end
    @(negedge clk);
    loadEn = 1'b0;
  endtask

  task automatic peekR(input int i, output logic [31:0] v);
    peekReg = 5'(i);
    #0.1;
    v = peekRegData;
  endtask

  task automatic peekM(input int i, output logic [31:0] v);
    peekMemAddr = 6'(i);
    #0.1;
    v = peekMemData;
  endtask

  task automatic runProg(input int cycles);
    @(negedge clk);
    rst = 1'b0;
    mPc = 32'd0;
    chk("R1 pc at release", pc, 32'd0);
    mStep();
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      chk(lastTag, pc, mPc);
      mStep();
    end
    @(negedge clk);
    chk(lastTag, pc, mPc);
    rst = 1'b1;
  endtask

  task automatic compareState();
    logic [31:0] v;
    peekR(0, v);
    chk("R5 r0 reads zero", v, 32'd0);
    for (int r = 1; r < 32; r++) begin
      if (mValid[r]) begin
        peekR(r, v);
        chk("R2 register state", v, mReg[r]);
      end
    end
    for (int m = 0; m < 64; m++) begin
      peekM(m, v);
      chk("R7 data memory state", v, mDmem[m]);
    end
  endtask

  function automatic logic [31:0] randInstr();
    int sel;
    logic [5:0] fns [5];
    logic [5:0] bad [4];
    int rs;
    fns = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h2A};
    bad = '{6'h00, 6'h21, 6'h27, 6'h3F};
    sel = int'($urandom % 12);
    rs  = int'($urandom % 32);
    case (sel)
      0, 1, 2, 3, 4: return encR(rs, int'($urandom % 32), int'($urandom % 32), fns[sel]);
      5: return encI(35, rs, int'($urandom % 32), 16'($urandom));
      6: return encI(43, rs, int'($urandom % 32), 16'($urandom));
      7, 8: return encI(4, rs, (($urandom % 3) == 0) ? rs : int'($urandom % 32),
                        16'(int'($urandom % 9) - 4));
      9: return encJ(int'($urandom % 64));
      10: return encR(rs, int'($urandom % 32), int'($urandom % 32), bad[$urandom % 4]);
      default: return {(($urandom % 2) == 0) ? 6'd63 : 6'd5, 26'($urandom)};
    endcase
  endfunction

  initial begin
    #(HALF * 2 * 190000);
    nBad++;
    nCmp++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [31:0] v, keep;
    void'($urandom(32'h00C0FFEE));
    for (int i = 0; i < 32; i++) begin
      mReg[i] = '0;
      mValid[i] = 1'b0;
    end
    for (int i = 0; i < 64; i++) begin
      mImem[i] = 32'd0;
      mDmem[i] = (32'(i) * 32'h01010101) ^ 32'h5A5A0000;
    end
    mDmem[0] = 32'd5;
    mDmem[1] = 32'hFFFFFFFD;

    // directed program
    mImem[0]  = encI(35, 0, 1, 16'd0);
    mImem[1]  = encI(35, 0, 2, 16'd4);
    mImem[2]  = encR(1, 2, 3, 6'h20);
    mImem[3]  = encR(1, 2, 4, 6'h22);
    mImem[4]  = encR(1, 2, 5, 6'h24);
    mImem[5]  = encR(1, 2, 6, 6'h25);
    mImem[6]  = encR(2, 1, 7, 6'h2A);
    mImem[7]  = encR(1, 2, 8, 6'h2A);
    mImem[8]  = encR(1, 1, 0, 6'h20);
    mImem[9]  = encI(43, 0, 4, 16'd12);
    mImem[10] = encI(35, 4, 9, 16'hFFFC);
    mImem[11] = encR(1, 0, 10, 6'h20);
    mImem[12] = encR(2, 2, 10, 6'h3F);
    mImem[13] = 32'd0;
    mImem[14] = encI(63, 1, 10, 16'd1);
    mImem[15] = encI(4, 1, 2, 16'd5);
    mImem[16] = encI(4, 1, 10, 16'd2);
    mImem[17] = encR(1, 1, 11, 6'h20);
    mImem[18] = encR(1, 1, 11, 6'h20);
    mImem[19] = encR(1, 1, 12, 6'h20);
    mImem[20] = encJ(23);
    mImem[21] = encR(1, 1, 13, 6'h20);
    mImem[22] = encR(1, 1, 13, 6'h20);
    mImem[23] = encI(4, 0, 0, 16'hFFFF);

    loadAll();
    repeat (2) @(negedge clk);
    chk("R1 pc held in reset", pc, 32'd0);
    peekM(1, v);
    chk("R11 preload visible", v, 32'hFFFFFFFD);

    runProg(40);
    chk("R9 directed final pc", pc, 32'd92);
    peekR(3, v);  chk("R2 add", v, 32'd2);
    peekR(4, v);  chk("R2 sub", v, 32'd8);
    peekR(5, v);  chk("R2 and", v, 32'd5);
    peekR(6, v);  chk("R2 or", v, 32'hFFFFFFFD);
    peekR(7, v);  chk("R3 slt true signed", v, 32'd1);
    peekR(8, v);  chk("R3 slt false signed", v, 32'd0);
    peekR(0, v);  chk("R5 write to r0 dropped", v, 32'd0);
    peekR(9, v);  chk("R6 load negative offset", v, 32'hFFFFFFFD);
    peekM(3, v);  chk("R7 store word", v, 32'd8);
    peekR(10, v); chk("R4 unsupported encodings write nothing", v, 32'd5);
    peekR(12, v); chk("R8 branch target reached", v, 32'd10);
    compareState();

    // random programs
    for (int p = 0; p < 25; p++) begin
      for (int i = 0; i < 31; i++) mImem[i] = encI(35, 0, i + 1, 16'(4 * i));
      for (int i = 31; i < 63; i++) mImem[i] = randInstr();
      mImem[63] = encI(4, 0, 0, 16'hFFFF);
      for (int i = 0; i < 64; i++) mDmem[i] = $urandom;
      keep = mReg[1];
      loadAll();
      repeat (3) @(negedge clk);
      chk("R1 pc held in reset", pc, 32'd0);
      peekR(1, v);
      chk("R1 no register write in reset", v, keep);
      peekM(p % 64, v);
      chk("R11 preload visible", v, mDmem[p % 64]);
      runProg(150);
      compareState();
    end

    finishRun();
  end

endmodule